// File: doc/BRIEF.md
# Modem Line Control with Edge Interrupt

This block handles the modem-control side of a serial port. Two control bits drive the DTR and RTS pins. The pins carry the inverse of each written bit, so writing a one drives the pin low. A third control bit turns on loopback, which sends the transmit data straight back into the receive input.

On the input side, the four active-low status lines RI, CTS, DCD and DSR each pass through a synchroniser. Software can read their levels. The block watches CTS and DCD for edges and latches each edge as a status flag. Each of these two lines has a mode bit that picks between falling-edge-only and any-edge sensing, and a mask bit that decides whether its flag counts towards the interrupt.

A read of the external-input register clears both flags. The masked flags are ORed into one pending bit, and that pending bit is gated by a top-level enable to form the interrupt output.

Top module: `modem_line_ctl`

## Requirements
- R1: After reset, `dtr_n_o` and `rts_n_o` are 1, `ext_irq_o` is 0, and the external-input register (address 1) reads 0x000F with all four pins high.
- R2: The line-control register (address 0) holds DTR in bit 0, RTS in bit 1 and loopback in bit 2, and it reads back as written. After a write, `dtr_n_o` equals the inverse of bit 0 and `rts_n_o` equals the inverse of bit 1.
- R3: When the loopback bit is 1, `rx_o` follows `tx_i`. When it is 0, `rx_o` follows `rx_pin_i`.
- R4: Address 1 bits 3:0 give the synchronised levels of RI (bit 0), CTS (bit 1), DCD (bit 2) and DSR (bit 3). A change at a pin first shows after the second rising clock edge.
- R5: When the any-edge mode bit of a line is 0 (bit 8 for CTS, bit 9 for DCD), only a high-to-low pin transition sets its status flag (bit 4 for CTS, bit 5 for DCD). The flag is first visible after the third rising clock edge following the pin change.
- R6: When the any-edge mode bit of a line is 1, a transition in either direction sets its status flag.
- R7: A read of address 1 (`reg_rd` high) returns the flags and clears them at that clock edge. An edge that lands in the same cycle as the clearing read leaves its flag set.
- R8: The interrupt register (address 2) bit 1 is 1 exactly when a status flag and its mask bit are both 1. The mask bits sit at address 1 bit 6 for CTS and bit 7 for DCD. Flags latch whether or not they are masked.
- R9: `ext_irq_o` is 1 exactly when address 2 bit 1 is 1 and the enable at address 2 bit 0 is 1.
- R10: Edges on RI and DSR never set any status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clears flags when reading address 1 |
| reg_addr | input | 2 | Register address: 0 line control, 1 external input, 2 interrupt |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| ri_n_i | input | 1 | Ring indicate pin, active low |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dcd_n_i | input | 1 | Carrier detect pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| dtr_n_o | output | 1 | DTR pin, inverse of control bit 0 |
| rts_n_o | output | 1 | RTS pin, inverse of control bit 1 |
| tx_i | input | 1 | Transmit data from the serialiser |
| rx_pin_i | input | 1 | Receive data from the pin |
| rx_o | output | 1 | Receive data to the deserialiser |
| ext_irq_o | output | 1 | Combined modem-line interrupt |

## Verification
Several internal faults show at the ports and are checked there:
- A stuck or misaligned synchroniser stage moves the level readback and the flag onset away from the second and third clock edges. The bench samples on exactly those edges, so a one-cycle slip is caught at once.
- A wrong edge-direction decode, or a flag that RI or DSR can reach, sets a flag that should stay clear. The very next peek of address 1 shows it.
- A clear that wins over a coinciding edge loses an event. Address 1 then reads zero one cycle after the clearing read.
- A broken mask or enable path appears on `ext_irq_o` in the cycle after the register write.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned NUM_PINS = 4;
  localparam int unsigned NUM_EDGE = 2;

  // pin order in the synchronised level vector
  localparam int unsigned PIN_RI  = 0;
  localparam int unsigned PIN_CTS = 1;
  localparam int unsigned PIN_DCD = 2;
  localparam int unsigned PIN_DSR = 3;

  // external-input register fields (edge lines ordered CTS, DCD)
  localparam int unsigned F_LVL = 0;
  localparam int unsigned F_STS = 4;
  localparam int unsigned F_MSK = 6;
  localparam int unsigned F_ANY = 8;

  // line-control register fields
  localparam int unsigned L_DTR  = 0;
  localparam int unsigned L_LOOP = 2;

  // interrupt register fields
  localparam int unsigned I_ENA  = 0;
  localparam int unsigned I_PEND = 1;

  typedef enum logic [ADDR_W-1:0] {
    ADR_LINE = 2'd0,
    ADR_EXT  = 2'd1,
    ADR_IRQ  = 2'd2
  } mlc_addr_e;

  typedef struct packed {
    logic loop_en;
    logic rts_bit;
    logic dtr_bit;
  } line_ctl_t;
endpackage

// File: rtl/mlc_sync.sv
module mlc_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // STAGES must be at least 2
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mlc_edge_flag.sv
module mlc_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic any_mode_i,
  input  logic clr_i,
  output logic status_o
);
  logic prev_q;
  logic sts_q;
  logic sts_d;
  logic fall_w;
  logic rise_w;
  logic hit_w;

  always_comb begin
    fall_w = prev_q & ~lvl_i;
    rise_w = ~prev_q & lvl_i;
    hit_w  = fall_w | (any_mode_i & rise_w);
    // a coinciding edge wins over the clear
    sts_d  = (sts_q & ~clr_i) | hit_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      sts_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      sts_q  <= sts_d;
    end
  end

  assign status_o = sts_q;
endmodule

// File: rtl/mlc_ctl_regs.sv
module mlc_ctl_regs
  import mlc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output line_ctl_t           line_q,
  output logic [NUM_EDGE-1:0] emask_q,
  output logic [NUM_EDGE-1:0] any_q,
  output logic                irq_ena_q
);
  logic                line_we;
  logic                ext_we;
  logic                irq_we;
  line_ctl_t           line_d;
  logic [NUM_EDGE-1:0] emask_d;
  logic [NUM_EDGE-1:0] any_d;
  logic                irq_ena_d;

  always_comb begin
    line_we   = wr_en && (addr == ADR_LINE);
    ext_we    = wr_en && (addr == ADR_EXT);
    irq_we    = wr_en && (addr == ADR_IRQ);
    line_d    = line_we ? line_ctl_t'(wdata[L_LOOP:L_DTR]) : line_q;
    emask_d   = ext_we ? wdata[F_MSK +: NUM_EDGE] : emask_q;
    any_d     = ext_we ? wdata[F_ANY +: NUM_EDGE] : any_q;
    irq_ena_d = irq_we ? wdata[I_ENA] : irq_ena_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= '0;
      emask_q   <= '0;
      any_q     <= '0;
      irq_ena_q <= 1'b0;
    end else begin
      line_q    <= line_d;
      emask_q   <= emask_d;
      any_q     <= any_d;
      irq_ena_q <= irq_ena_d;
    end
  end
endmodule

// File: rtl/modem_line_ctl.sv
module modem_line_ctl
  import mlc_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ri_n_i,
  input  logic              cts_n_i,
  input  logic              dcd_n_i,
  input  logic              dsr_n_i,
  output logic              dtr_n_o,
  output logic              rts_n_o,
  input  logic              tx_i,
  input  logic              rx_pin_i,
  output logic              rx_o,
  output logic              ext_irq_o
);
  logic [1:0]          rst_sq;
  logic                rst_q;
  logic [NUM_PINS-1:0] pins_w;
  logic [NUM_PINS-1:0] lvl_w;
  logic [NUM_EDGE-1:0] sts_w;
  logic [NUM_EDGE-1:0] emask_w;
  logic [NUM_EDGE-1:0] any_w;
  logic                irq_ena_w;
  line_ctl_t           line_w;
  logic                ext_rd_w;
  logic                pend_w;
  logic [DATA_W-1:0]   rdata_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sq <= 2'b00;
    end else begin
      rst_sq <= {rst_sq[0], 1'b1};
    end
  end
  assign rst_q = rst_sq[1];

  assign pins_w = {dsr_n_i, dcd_n_i, cts_n_i, ri_n_i};

  mlc_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NUM_PINS{1'b1}})
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_q),
    .d_i  (pins_w),
    .q_o  (lvl_w)
  );

  mlc_ctl_regs #(.DATA_W(DATA_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .line_q   (line_w),
    .emask_q  (emask_w),
    .any_q    (any_w),
    .irq_ena_q(irq_ena_w)
  );

  assign ext_rd_w = reg_rd && (reg_addr == ADR_EXT);

  for (genvar g = 0; g < NUM_EDGE; g++) begin : g_edge
    localparam int unsigned PIN_IDX = (g == 0) ? PIN_CTS : PIN_DCD;
    mlc_edge_flag flag_i (
      .clk       (clk),
      .rst_n     (rst_q),
      .lvl_i     (lvl_w[PIN_IDX]),
      .any_mode_i(any_w[g]),
      .clr_i     (ext_rd_w),
      .status_o  (sts_w[g])
    );
  end

  always_comb begin
    pend_w    = |(sts_w & emask_w);
    ext_irq_o = pend_w & irq_ena_w;
    dtr_n_o   = ~line_w.dtr_bit;
    rts_n_o   = ~line_w.rts_bit;
    rx_o      = line_w.loop_en ? tx_i : rx_pin_i;
  end

  always_comb begin
    rdata_d = '0;
    case (reg_addr)
      ADR_LINE: rdata_d[L_LOOP:L_DTR] = line_w;
      ADR_EXT: begin
        rdata_d[F_LVL +: NUM_PINS] = lvl_w;
        rdata_d[F_STS +: NUM_EDGE] = sts_w;
        rdata_d[F_MSK +: NUM_EDGE] = emask_w;
        rdata_d[F_ANY +: NUM_EDGE] = any_w;
      end
      ADR_IRQ: begin
        rdata_d[I_ENA]  = irq_ena_w;
        rdata_d[I_PEND] = pend_w;
      end
      default: rdata_d = '0;
    endcase
  end
  assign reg_rdata = rdata_d;
endmodule

// File: rtl/modem_line_ctl_chk.sv
module modem_line_ctl_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_q,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              dtr_n_o,
  input logic              rts_n_o,
  input logic              ext_irq_o,
  input logic [1:0]        sts_w,
  input logic [1:0]        emask_w,
  input logic [3:0]        lvl_w
);
  a_r2_dtr_inverse: assert property (@(posedge clk) disable iff (!rst_q)
    (reg_wr && reg_addr == 2'd0) |=> (dtr_n_o == !$past(reg_wdata[0])));

  a_r2_rts_inverse: assert property (@(posedge clk) disable iff (!rst_q)
    (reg_wr && reg_addr == 2'd0) |=> (rts_n_o == !$past(reg_wdata[1])));

  a_r5_cts_needs_edge: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(sts_w[0]) |-> ($past(lvl_w[1]) != $past(lvl_w[1], 2)));

  a_r5_dcd_needs_edge: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(sts_w[1]) |-> ($past(lvl_w[2]) != $past(lvl_w[2], 2)));

  a_r7_cts_held: assert property (@(posedge clk) disable iff (!rst_q)
    (sts_w[0] && !(reg_rd && reg_addr == 2'd1)) |=> sts_w[0]);

  a_r7_dcd_held: assert property (@(posedge clk) disable iff (!rst_q)
    (sts_w[1] && !(reg_rd && reg_addr == 2'd1)) |=> sts_w[1]);

  a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_q)
    ext_irq_o |-> ((sts_w & emask_w) != 2'b00));
endmodule

bind modem_line_ctl modem_line_ctl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_q    (rst_q),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .dtr_n_o  (dtr_n_o),
  .rts_n_o  (rts_n_o),
  .ext_irq_o(ext_irq_o),
  .sts_w    (sts_w),
  .emask_w  (emask_w),
  .lvl_w    (lvl_w)
);

// File: tb/modem_line_ctl_tb_top.sv
`timescale 1ns/1ps
module modem_line_ctl_tb_top;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr, reg_rd;
  logic [1:0]    reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic          ri_n, cts_n, dcd_n, dsr_n;
  logic          dtr_n, rts_n, tx, rx_pin, rx_o, ext_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // vector: [7:5] line-control write, [4] tx, [3] rx pin,
  //         [2] expected dtr_n, [1] expected rts_n, [0] expected rx_o
  localparam logic [7:0] VEC [8] = '{
    8'b000_1_0_1_1_0, 8'b001_0_1_0_1_1, 8'b010_1_0_1_0_0, 8'b011_0_1_0_0_1,
    8'b100_1_0_1_1_1, 8'b101_0_1_0_1_0, 8'b110_0_1_1_0_0, 8'b111_1_0_0_0_1
  };

  always #2.5 clk = ~clk;

  modem_line_ctl #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ri_n_i(ri_n), .cts_n_i(cts_n), .dcd_n_i(dcd_n), .dsr_n_i(dsr_n),
    .dtr_n_o(dtr_n), .rts_n_o(rts_n), .tx_i(tx), .rx_pin_i(rx_pin),
    .rx_o(rx_o), .ext_irq_o(ext_irq)
  );

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic rd_clr(output int v);
    reg_rd = 1'b1; reg_addr = 2'd1;
    #1;
    v = int'(reg_rdata);
    tick(1);
    reg_rd = 1'b0;
  endtask

  function automatic int sts(input int v);
    return (v >> 4) & 3;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    ri_n = 1'b1; cts_n = 1'b1; dcd_n = 1'b1; dsr_n = 1'b1; tx = 1'b0; rx_pin = 1'b0;
    @(negedge clk);
    tick(2);
    rst_n = 1'b1;
    tick(3);

    // R1 reset state
    check("R1 dtr_n", int'(dtr_n), 1);
    check("R1 rts_n", int'(rts_n), 1);
    check("R1 ext_irq", int'(ext_irq), 0);
    peek(2'd1, v); check("R1 ext reg", v, 'h000F);

    // R2 / R3 table walk
    for (int i = 0; i < 8; i++) begin
      tx = VEC[i][4]; rx_pin = VEC[i][3];
      wr(2'd0, DW'(VEC[i][7:5]));
      check("R2 dtr_n", int'(dtr_n), int'(VEC[i][2]));
      check("R2 rts_n", int'(rts_n), int'(VEC[i][1]));
      check("R3 rx_o", int'(rx_o), int'(VEC[i][0]));
      peek(2'd0, v); check("R2 readback", v, int'(VEC[i][7:5]));
    end
    wr(2'd0, '0);

    // R4 levels and R10 RI/DSR edges, with any-edge mode on both lines
    wr(2'd1, 'h300);
    ri_n = 1'b0; dsr_n = 1'b0;
    tick(1);
    peek(2'd1, v); check("R4 level after one edge", v & 'hF, 'hF);
    tick(1);
    peek(2'd1, v); check("R4 level after two edges", v & 'hF, 'h6);
    tick(2);
    peek(2'd1, v); check("R10 no flag on RI/DSR fall", sts(v), 0);
    ri_n = 1'b1; dsr_n = 1'b1;
    tick(4);
    peek(2'd1, v); check("R10 no flag on RI/DSR rise", sts(v), 0);
    wr(2'd1, 'h000);

    // R5 falling only
    cts_n = 1'b0;
    tick(2);
    peek(2'd1, v); check("R5 flag not before third edge", sts(v), 0);
    tick(1);
    peek(2'd1, v); check("R5 flag on CTS fall", sts(v), 1);
    rd_clr(v); check("R7 read returns flag", sts(v), 1);
    peek(2'd1, v); check("R7 read clears flag", sts(v), 0);
    cts_n = 1'b1;
    tick(4);
    peek(2'd1, v); check("R5 rise ignored", sts(v), 0);

    // R6 any edge on DCD
    wr(2'd1, 'h200);
    dcd_n = 1'b0;
    tick(3);
    peek(2'd1, v); check("R6 DCD fall", sts(v), 2);
    rd_clr(v);
    dcd_n = 1'b1;
    tick(3);
    peek(2'd1, v); check("R6 DCD rise", sts(v), 2);
    rd_clr(v);

    // R8 / R9 mask and enable
    cts_n = 1'b0;
    tick(3);
    peek(2'd1, v); check("R8 flag latched while masked", sts(v), 1);
    peek(2'd2, v); check("R8 pending masked off", (v >> 1) & 1, 0);
    check("R9 irq low", int'(ext_irq), 0);
    wr(2'd1, 'h240);
    peek(2'd1, v); check("R8 mask readback", (v >> 6) & 'hF, 'h9);
    peek(2'd2, v); check("R8 pending", (v >> 1) & 1, 1);
    check("R9 irq low without enable", int'(ext_irq), 0);
    wr(2'd2, 'h1);
    check("R9 irq high", int'(ext_irq), 1);
    wr(2'd1, 'h280);
    peek(2'd2, v); check("R8 other mask only", (v >> 1) & 1, 0);
    check("R9 irq low other mask", int'(ext_irq), 0);
    wr(2'd1, 'h240);
    check("R9 irq back", int'(ext_irq), 1);
    rd_clr(v);
    check("R9 irq cleared by read", int'(ext_irq), 0);

    // R7 edge coinciding with clearing read
    wr(2'd1, 'h340);
    cts_n = 1'b1;
    tick(3);
    peek(2'd1, v); check("R6 CTS rise in any mode", sts(v), 1);
    cts_n = 1'b0;
    tick(2);
    rd_clr(v); check("R7 read sees old flag", sts(v), 1);
    peek(2'd1, v); check("R7 coinciding edge kept", sts(v), 1);
    check("R7 irq still high", int'(ext_irq), 1);
    rd_clr(v);
    peek(2'd1, v); check("R7 plain clear", sts(v), 0);
    check("R9 irq low after clear", int'(ext_irq), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule